// File: doc/BRIEF.md
# Dual-Side Processor Messaging Unit

This block connects two processors, called side A and side B, through a mailbox. Each side has its own 32-bit register port with four transmit data registers, four receive data registers, a status register and a control register. A word that one side writes to transmit register n is captured and shown in receive register n of the other side. A full/empty flag pair for each channel and each direction carries the handshake. Writing a transmit register marks the word as waiting. Reading it on the far side frees the slot again.

Each side also has four doorbells. A request bit in a side's control register raises a pending flag on the peer. The hardware then drops the request. The peer clears the pending flag by writing one to it. Each side has one interrupt line. The line combines its receive-full, transmit-empty and doorbell-pending flags, each gated by its own enable bit. A synchronous per-side reset input clears that side's control register. While that input is held, the peer's status shows a flag.

Top module: `mu_dual_side`

## Requirements
- R1: A write to byte offset 4·n (n = 0..3) on one side is returned by a read of offset 0x10 + 4·n on the peer. A later write replaces the earlier word.
- R2: The status register is at 0x20. Receive-full for channel n is bit 27−n and transmit-empty for channel n is bit 23−n. The write to a transmit register takes effect at the clock edge that accepts it: the writer's transmit-empty n clears and the peer's receive-full n sets. If a write and a peer read of the same channel land in the same cycle, the write wins.
- R3: A read of receive register n clears that side's receive-full n and sets the peer's transmit-empty n at the accepting edge.
- R4: The control register is at 0x24. Writing 1 to request bit 19−n sets the peer's pending flag n (status bit 31−n) one cycle later. The request bit then returns to 0 with no software action.
- R5: Writing 1 to status bit 31−n clears pending flag n. Writing 0 has no effect, and writes to every other status bit are ignored.
- R6: The interrupt output of a side is high exactly while one of these holds for some n: pending n with enable bit 31−n, receive-full n with enable bit 27−n, or transmit-empty n with enable bit 23−n. It follows the flags in the same cycle.
- R7: After reset the control registers are 0, all transmit-empty flags are 1, all receive-full and pending flags are 0, and both interrupts are low. Each status register therefore reads 0x00F00000.
- R8: Control bits 15:0, status bits outside the flag fields and bit 9, and reads of the transmit offsets or of unmapped offsets all return 0.
- R9: While a side's synchronous reset input is high, its control register is held at 0 and status bit 9 of the peer reads 1. Otherwise bit 9 reads 0.
- R10: Read data appears on the read data output in the cycle after the request is accepted and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock shared by both sides |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_srst_i | input | 1 | Side A synchronous reset of its control register |
| a_req_i | input | 1 | Side A access request |
| a_we_i | input | 1 | Side A write (1) or read (0) |
| a_addr_i | input | 6 | Side A byte offset |
| a_wdata_i | input | 32 | Side A write data |
| a_rdata_o | output | 32 | Side A read data, one cycle after request |
| a_irq_o | output | 1 | Side A combined interrupt |
| b_srst_i | input | 1 | Side B synchronous reset of its control register |
| b_req_i | input | 1 | Side B access request |
| b_we_i | input | 1 | Side B write (1) or read (0) |
| b_addr_i | input | 6 | Side B byte offset |
| b_wdata_i | input | 32 | Side B write data |
| b_rdata_o | output | 32 | Side B read data, one cycle after request |
| b_irq_o | output | 1 | Side B combined interrupt |

## Verification
Flags and data registers change at the edge that accepts a write or read. The interrupt lines follow with no register in between, so the bench samples them at the falling edge just after the access. A doorbell needs one edge to set the peer's pending flag and a second edge to drop the request bit. For this reason the bench always lets at least one idle cycle pass before it reads back either one. Read data is registered, so every read result is taken at the falling edge after the accepting edge. The sweeps cover each channel in both directions, with expected words and status values built from shifted bit positions.

// File: rtl/mu_pkg.sv
package mu_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned ADDR_W  = 6;
  localparam int unsigned N_CH    = 4;
  localparam int unsigned N_SIDE  = 2;
  // top bit of each per-channel field; channel n sits at HI - n
  localparam int unsigned GP_HI   = 31;
  localparam int unsigned RF_HI   = 27;
  localparam int unsigned TE_HI   = 23;
  localparam int unsigned RQ_HI   = 19;
  localparam int unsigned PRST_BIT = 9;
  localparam logic [3:0] WSEL_STAT = 4'h8;
  localparam logic [3:0] WSEL_CTRL = 4'h9;
endpackage

// File: rtl/mu_link.sv
module mu_link #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic         rd_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] data_o,
  output logic         full_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      full_o <= 1'b0;
    end else if (wr_i) begin
      data_o <= wdata_i;
      full_o <= 1'b1;
    end else if (rd_i) begin
      full_o <= 1'b0;
    end
  end
endmodule

// File: rtl/mu_bell.sv
module mu_bell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pend_o <= 1'b0;
    else if (pend_o) pend_o <= ~clr_i;
    else             pend_o <= set_i;
  end
endmodule

// File: rtl/mu_port.sv
module mu_port
  import mu_pkg::*;
#(
  parameter int unsigned NCH = N_CH,
  parameter int unsigned W   = WORD_W,
  parameter int unsigned AW  = ADDR_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  srst_i,
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic [AW-1:0]         addr_i,
  input  logic [W-1:0]          wdata_i,
  output logic [W-1:0]          rdata_o,
  output logic                  irq_o,
  input  logic [NCH-1:0]        te_i,
  input  logic [NCH-1:0]        rf_i,
  input  logic [NCH-1:0]        gp_i,
  input  logic [NCH-1:0]        peer_gp_i,
  input  logic                  peer_rst_i,
  input  logic [NCH-1:0][W-1:0] rx_data_i,
  output logic [NCH-1:0]        tx_wr_o,
  output logic [NCH-1:0]        rx_rd_o,
  output logic [NCH-1:0]        gir_o,
  output logic [NCH-1:0]        gp_clr_o
);
  localparam int unsigned IW = $clog2(NCH);

  logic          aligned, sel_tx, sel_rx, sel_stat, sel_ctrl, wr, rd;
  logic [IW-1:0] idx;
  logic [NCH-1:0] gie_q, rie_q, tie_q, gir_q;
  logic [NCH-1:0] gie_d, rie_d, tie_d, gir_d;
  logic [W-1:0]  stat_w, ctrl_w;

  assign aligned  = (addr_i[1:0] == 2'b00);
  assign sel_tx   = aligned && (addr_i[AW-1:4] == 2'b00);
  assign sel_rx   = aligned && (addr_i[AW-1:4] == 2'b01);
  assign sel_stat = aligned && (addr_i[AW-1:2] == WSEL_STAT);
  assign sel_ctrl = aligned && (addr_i[AW-1:2] == WSEL_CTRL);
  assign idx      = addr_i[2+:IW];
  assign wr       = req_i & we_i;
  assign rd       = req_i & ~we_i;

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    assign tx_wr_o[n]  = wr & sel_tx & (idx == IW'(n));
    assign rx_rd_o[n]  = rd & sel_rx & (idx == IW'(n));
    assign gp_clr_o[n] = wr & sel_stat & wdata_i[GP_HI-n];
    assign gie_d[n]    = wdata_i[GP_HI-n];
    assign rie_d[n]    = wdata_i[RF_HI-n];
    assign tie_d[n]    = wdata_i[TE_HI-n];
    assign gir_d[n]    = wdata_i[RQ_HI-n];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gie_q <= '0; rie_q <= '0; tie_q <= '0; gir_q <= '0;
    end else if (srst_i) begin
      gie_q <= '0; rie_q <= '0; tie_q <= '0; gir_q <= '0;
    end else if (wr && sel_ctrl) begin
      gie_q <= gie_d; rie_q <= rie_d; tie_q <= tie_d; gir_q <= gir_d;
    end else begin
      gir_q <= gir_q & ~peer_gp_i;  // request retires once the peer shows it
    end
  end

  always_comb begin
    stat_w = '0;
    ctrl_w = '0;
    for (int n = 0; n < NCH; n++) begin
      stat_w[GP_HI-n] = gp_i[n];
      stat_w[RF_HI-n] = rf_i[n];
      stat_w[TE_HI-n] = te_i[n];
      ctrl_w[GP_HI-n] = gie_q[n];
      ctrl_w[RF_HI-n] = rie_q[n];
      ctrl_w[TE_HI-n] = tie_q[n];
      ctrl_w[RQ_HI-n] = gir_q[n];
    end
    stat_w[PRST_BIT] = peer_rst_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else if (rd) begin
      if (sel_rx)        rdata_o <= rx_data_i[idx];
      else if (sel_stat) rdata_o <= stat_w;
      else if (sel_ctrl) rdata_o <= ctrl_w;
      else               rdata_o <= '0;
    end
  end

  assign gir_o = gir_q;
  assign irq_o = |((gp_i & gie_q) | (rf_i & rie_q) | (te_i & tie_q));
endmodule

// File: rtl/mu_dual_side.sv
module mu_dual_side
  import mu_pkg::*;
#(
  parameter int unsigned NCH = N_CH,
  parameter int unsigned W   = WORD_W,
  parameter int unsigned AW  = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          a_srst_i,
  input  logic          a_req_i,
  input  logic          a_we_i,
  input  logic [AW-1:0] a_addr_i,
  input  logic [W-1:0]  a_wdata_i,
  output logic [W-1:0]  a_rdata_o,
  output logic          a_irq_o,
  input  logic          b_srst_i,
  input  logic          b_req_i,
  input  logic          b_we_i,
  input  logic [AW-1:0] b_addr_i,
  input  logic [W-1:0]  b_wdata_i,
  output logic [W-1:0]  b_rdata_o,
  output logic          b_irq_o
);
  logic [N_SIDE-1:0]                srst, req, we, irq;
  logic [N_SIDE-1:0][AW-1:0]        addr;
  logic [N_SIDE-1:0][W-1:0]         wdata, rdata;
  logic [N_SIDE-1:0][NCH-1:0]       tx_wr, rx_rd, gir, gp_clr;
  // lnk_*[s]: traffic from side s to its peer; bell_pend[s]: raised by s, seen by peer
  logic [N_SIDE-1:0][NCH-1:0]       lnk_full, bell_pend;
  logic [N_SIDE-1:0][NCH-1:0][W-1:0] lnk_data;

  assign srst  = {b_srst_i, a_srst_i};
  assign req   = {b_req_i, a_req_i};
  assign we    = {b_we_i, a_we_i};
  assign addr  = {b_addr_i, a_addr_i};
  assign wdata = {b_wdata_i, a_wdata_i};
  assign a_rdata_o = rdata[0];
  assign b_rdata_o = rdata[1];
  assign a_irq_o   = irq[0];
  assign b_irq_o   = irq[1];

  for (genvar s = 0; s < N_SIDE; s++) begin : g_side
    localparam int unsigned P = N_SIDE - 1 - s;

    mu_port #(.NCH(NCH), .W(W), .AW(AW)) u_port (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .srst_i     (srst[s]),
      .req_i      (req[s]),
      .we_i       (we[s]),
      .addr_i     (addr[s]),
      .wdata_i    (wdata[s]),
      .rdata_o    (rdata[s]),
      .irq_o      (irq[s]),
      .te_i       (~lnk_full[s]),
      .rf_i       (lnk_full[P]),
      .gp_i       (bell_pend[P]),
      .peer_gp_i  (bell_pend[s]),
      .peer_rst_i (srst[P]),
      .rx_data_i  (lnk_data[P]),
      .tx_wr_o    (tx_wr[s]),
      .rx_rd_o    (rx_rd[s]),
      .gir_o      (gir[s]),
      .gp_clr_o   (gp_clr[s])
    );

    for (genvar n = 0; n < NCH; n++) begin : g_ch
      mu_link #(.W(W)) u_link (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_i    (tx_wr[s][n]),
        .rd_i    (rx_rd[P][n]),
        .wdata_i (wdata[s]),
        .data_o  (lnk_data[s][n]),
        .full_o  (lnk_full[s][n])
      );

      mu_bell u_bell (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .set_i  (gir[s][n]),
        .clr_i  (gp_clr[P][n]),
        .pend_o (bell_pend[s][n])
      );
    end
  end
endmodule

// File: rtl/mu_dual_side_chk.sv
module mu_dual_side_chk #(
  parameter int unsigned NCH = 4,
  parameter int unsigned W   = 32,
  parameter int unsigned AW  = 6
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 a_srst_i,
  input logic                 a_req_i,
  input logic                 a_we_i,
  input logic [AW-1:0]        a_addr_i,
  input logic [W-1:0]         a_rdata_o,
  input logic                 a_irq_o,
  input logic                 b_req_i,
  input logic                 b_we_i,
  input logic [AW-1:0]        b_addr_i,
  input logic [W-1:0]         b_wdata_i,
  input logic [1:0][NCH-1:0]  lnk_full,
  input logic [1:0][NCH-1:0]  bell_pend,
  input logic [1:0][NCH-1:0]  gir
);
  logic a_tx_wr, b_rx_rd, same_ch, b_stat_wr;
  logic [NCH-1:0] b_clr;

  assign a_tx_wr   = a_req_i && a_we_i && (a_addr_i[5:4] == 2'b00) && (a_addr_i[1:0] == 2'b00);
  assign b_rx_rd   = b_req_i && !b_we_i && (b_addr_i[5:4] == 2'b01) && (b_addr_i[1:0] == 2'b00);
  assign same_ch   = a_tx_wr && (a_addr_i[3:2] == b_addr_i[3:2]);
  assign b_stat_wr = b_req_i && b_we_i && (b_addr_i == 6'h20);
  for (genvar n = 0; n < NCH; n++) begin : g_clr
    assign b_clr[n] = b_wdata_i[31-n];
  end

  assert_tx_sets_full_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_tx_wr |=> lnk_full[0][$past(a_addr_i[3:2])]);

  assert_rx_clears_full_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b_rx_rd && !same_ch) |=> !lnk_full[0][$past(b_addr_i[3:2])]);

  assert_bell_sets_pend_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(gir[0] & ~bell_pend[0])) |=> ((bell_pend[0] & $past(gir[0] & ~bell_pend[0])) == $past(gir[0] & ~bell_pend[0])));

  assert_w1c_pend_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_stat_wr |=> ((bell_pend[0] & $past(bell_pend[0] & b_clr)) == '0));

  assert_srst_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_srst_i |=> !a_irq_o);

  assert_rdata_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!a_req_i || a_we_i) |=> $stable(a_rdata_o));
endmodule

bind mu_dual_side mu_dual_side_chk #(.NCH(NCH), .W(W), .AW(AW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .a_srst_i  (a_srst_i),
  .a_req_i   (a_req_i),
  .a_we_i    (a_we_i),
  .a_addr_i  (a_addr_i),
  .a_rdata_o (a_rdata_o),
  .a_irq_o   (a_irq_o),
  .b_req_i   (b_req_i),
  .b_we_i    (b_we_i),
  .b_addr_i  (b_addr_i),
  .b_wdata_i (b_wdata_i),
  .lnk_full  (lnk_full),
  .bell_pend (bell_pend),
  .gir       (gir)
);

// File: tb/mu_dual_side_test.sv
`timescale 1ns/1ps
module mu_dual_side_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] srst = '0, req = '0, we = '0;
  logic [1:0][5:0] addr = '0;
  logic [1:0][31:0] wdata = '0;
  logic [31:0] a_rdata, b_rdata;
  logic a_irq, b_irq;
  int n_chk = 0, n_bad = 0;
  logic [31:0] rv;
  localparam logic [31:0] IDLE_SR = 32'h00F0_0000;

  always #10 clk = ~clk;

  mu_dual_side uut (
    .clk_i(clk), .rst_ni(rst_n),
    .a_srst_i(srst[0]), .a_req_i(req[0]), .a_we_i(we[0]), .a_addr_i(addr[0]),
    .a_wdata_i(wdata[0]), .a_rdata_o(a_rdata), .a_irq_o(a_irq),
    .b_srst_i(srst[1]), .b_req_i(req[1]), .b_we_i(we[1]), .b_addr_i(addr[1]),
    .b_wdata_i(wdata[1]), .b_rdata_o(b_rdata), .b_irq_o(b_irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic wr(input int s, input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    req[s] = 1'b1; we[s] = 1'b1; addr[s] = a; wdata[s] = d;
    @(negedge clk);
    req[s] = 1'b0; we[s] = 1'b0;
  endtask

  task automatic rd(input int s, input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    req[s] = 1'b1; we[s] = 1'b0; addr[s] = a;
    @(negedge clk);
    req[s] = 1'b0;
    d = (s == 0) ? a_rdata : b_rdata;
  endtask

  task automatic irq_of(input int s, output logic [31:0] v);
    v = {31'b0, (s == 0) ? a_irq : b_irq};
  endtask

  initial begin
    #(20ns * 200000);
    n_bad++;
    $display("FAIL watchdog: got 00000000 expected 00000001");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R7 reset state
    rd(0, 6'h20, rv); check("R7 A status", rv, IDLE_SR);
    rd(1, 6'h20, rv); check("R7 B status", rv, IDLE_SR);
    rd(0, 6'h24, rv); check("R7 A control", rv, 0);
    rd(1, 6'h24, rv); check("R7 B control", rv, 0);
    check("R7 irqs", {30'b0, b_irq, a_irq}, 0);

    // R1 R2 R3 R10 sweep every channel both directions
    for (int s = 0; s < 2; s++) begin
      for (int n = 0; n < 4; n++) begin
        logic [31:0] d;
        d = 32'hA500_0000 ^ (s << 12) ^ (n * 32'h0101_0101);
        wr(s, 6'(4 * n), d);
        rd(1 - s, 6'h20, rv); check("R2 peer rf", rv, IDLE_SR | (32'h1 << (27 - n)));
        rd(s, 6'h20, rv);     check("R2 own te", rv, IDLE_SR & ~(32'h1 << (23 - n)));
        rd(1 - s, 6'(16 + 4 * n), rv); check("R1 data", rv, d);
        rd(s, 6'h20, rv);     check("R3 te back", rv, IDLE_SR);
        rd(1 - s, 6'h20, rv); check("R3 rf cleared", rv, IDLE_SR);
      end
    end
    // R1 overwrite; all four full at once
    for (int n = 0; n < 4; n++) wr(0, 6'(4 * n), 32'h1111_0000 + n);
    wr(0, 6'h04, 32'hBEEF_0001);
    rd(1, 6'h20, rv); check("R2 all full peer", rv, 32'h0FF0_0000);
    rd(0, 6'h20, rv); check("R2 all full own", rv, 32'h0);
    rd(1, 6'h14, rv); check("R1 overwrite", rv, 32'hBEEF_0001);
    for (int n = 0; n < 4; n++) begin
      rd(1, 6'(16 + 4 * n), rv);
      if (n != 1) check("R1 multi", rv, 32'h1111_0000 + n);
    end
    rd(0, 6'h20, rv); check("R3 all empty", rv, IDLE_SR);

    // R4 R5 doorbells
    for (int s = 0; s < 2; s++) begin
      for (int n = 0; n < 4; n++) begin
        wr(s, 6'h24, 32'h1 << (19 - n));
        rd(1 - s, 6'h20, rv); check("R4 pend", rv, IDLE_SR | (32'h1 << (31 - n)));
        rd(s, 6'h24, rv);     check("R4 req retired", rv, 0);
        wr(1 - s, 6'h20, 32'h0);
        rd(1 - s, 6'h20, rv); check("R5 zero write", rv, IDLE_SR | (32'h1 << (31 - n)));
        wr(1 - s, 6'h20, ~(32'h1 << (31 - n)));
        rd(1 - s, 6'h20, rv); check("R5 other bits", rv, IDLE_SR | (32'h1 << (31 - n)));
        wr(1 - s, 6'h20, 32'h1 << (31 - n));
        rd(1 - s, 6'h20, rv); check("R5 w1c", rv, IDLE_SR);
      end
    end

    // R6 interrupts
    wr(1, 6'h24, 32'h1 << 25);
    irq_of(1, rv); check("R6 rie no flag", rv, 0);
    wr(0, 6'h08, 32'h0000_00C2);
    irq_of(1, rv); check("R6 rie flag", rv, 1);
    rd(1, 6'h18, rv); check("R1 ch2", rv, 32'h0000_00C2);
    irq_of(1, rv); check("R6 rie cleared", rv, 0);
    wr(1, 6'h24, 0);
    wr(0, 6'h24, 32'h1 << 22);
    irq_of(0, rv); check("R6 tie empty", rv, 1);
    wr(0, 6'h04, 32'h5);
    irq_of(0, rv); check("R6 tie full", rv, 0);
    rd(1, 6'h14, rv);
    irq_of(0, rv); check("R6 tie drained", rv, 1);
    wr(0, 6'h24, 32'h1 << 31);
    irq_of(0, rv); check("R6 gie idle", rv, 0);
    wr(1, 6'h24, 32'h1 << 19);
    @(negedge clk);
    irq_of(0, rv); check("R6 gie pend", rv, 1);
    wr(0, 6'h20, 32'h1 << 31);
    irq_of(0, rv); check("R6 gie cleared", rv, 0);

    // R8 unused bits
    wr(0, 6'h24, 32'hFFF0_FFFF);
    rd(0, 6'h24, rv); check("R8 control", rv, 32'hFFF0_0000);
    wr(0, 6'h24, 0);
    rd(0, 6'h0C, rv); check("R8 tx read", rv, 0);
    rd(0, 6'h30, rv); check("R8 unmapped", rv, 0);
    rd(0, 6'h22, rv); check("R8 unaligned", rv, 0);

    // R9 side reset
    wr(1, 6'h24, 32'h00F0_0000);
    irq_of(1, rv); check("R9 pre irq", rv, 1);
    @(negedge clk); srst[1] = 1'b1;
    rd(0, 6'h20, rv); check("R9 peer flag", rv, IDLE_SR | (32'h1 << 9));
    irq_of(1, rv); check("R9 irq off", rv, 0);
    @(negedge clk); srst[1] = 1'b0;
    rd(1, 6'h24, rv); check("R9 ctrl zero", rv, 0);
    rd(0, 6'h20, rv); check("R9 flag gone", rv, IDLE_SR);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule